// File: doc/BRIEF.md
# Pixel Hit Timing and Counting Logic

This block is the digital part of a column of hybrid pixels. Each pixel takes an already synchronized discriminator level and, while a common shutter is open, records the first hit it sees. In timing mode one hit yields two 4-bit numbers at once: how long before the shutter closed it arrived (arrival time) and how long the discriminator stayed high (duration). In counting mode the same eight bits form one saturating counter of discriminator pulses, used while the thresholds are being equalized. Each pixel raises a hit flag that zero-suppression logic further down the column can use to skip empty pixels.

Each pixel also holds a six-bit configuration word: a mask bit, a test-pulse select bit and a 4-bit threshold tuning value that drives the pixel's trim DAC. The words of all pixels form one serial chain that is loaded bit by bit. After the shutter closes, the eight data bits of every pixel become stages of a column-wide shift register, so the whole column is read out one bit per clock through a single serial output.

Top module: `pix_column`

## Requirements
- R1: While reset is high, at the next clock edge every data register, hit flag and configuration word is cleared, so hit_o, tune_o, rd_sout_o and cfg_sout_o all read 0.
- R2: Each pixel holds a 6-bit word {mask (bit 5), test-pulse select (bit 4), tune (bits 3:0)}. With cfg_shift_i high, on each clock edge every word shifts up one bit, cfg_sin_i enters bit 0 of pixel 0, bit 5 of pixel k feeds bit 0 of pixel k+1, and cfg_sout_o shows bit 5 of the last pixel; after 6*NPIX shifts the first bit sent sits in bit 5 of the last pixel. tune_o[4k+3:4k] shows pixel k's tune. With cfg_shift_i low the words hold.
- R3: The first clock edge at which shutter_i is sampled high clears all data and hit flags. Discriminator rising edges (input high at this edge, low at the previous one) are only recognised from the second shutter-high edge on, so a pulse already high at the opening edge is never recorded.
- R4: In timing mode (mode_i = 0) the arrival field (data bits 7:4) of a pixel whose first rising edge was seen at a shutter-high edge equals the number of later shutter-high edges, saturating at 15.
- R5: In timing mode the duration field (data bits 3:0) equals the number of consecutive shutter-high edges after the rising edge at which the input was still high, saturating at 15; a pulse seen at one edge only gives 0 but still sets the hit flag and records the arrival time.
- R6: In timing mode only the first pulse in a shutter window is measured; later pulses change neither field.
- R7: In counting mode (mode_i = 1) the 8-bit data word counts recognised rising edges as one binary number, saturating at 255, and the first edge sets the hit flag.
- R8: A pixel whose mask bit is 1 ignores its input: its hit flag stays 0 and its data stays 0 through the shutter window.
- R9: A pixel whose test-pulse select bit is 1 measures tp_pulse_i instead of its own disc_i bit.
- R10: With shutter_i low and rd_shift_i high, every pixel's 8-bit data word shifts up one bit per clock, rd_sin_i enters bit 0 of pixel 0, bit 7 of pixel k feeds pixel k+1, and rd_sout_o shows bit 7 of the last pixel, so the column streams out last pixel first, MSB first. rd_shift_i is ignored while shutter_i is high.
- R11: A hit flag holds from the edge that sets it until the next shutter opening, including throughout readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for acquisition, configuration and readout |
| rst | input | 1 | Synchronous active-high reset |
| shutter_i | input | 1 | Acquisition window, high while open |
| mode_i | input | 1 | 0 = arrival time and duration, 1 = pulse counting |
| tp_pulse_i | input | 1 | Test pulse used by pixels with test-pulse select set |
| disc_i | input | NPIX | Synchronized discriminator level per pixel |
| cfg_shift_i | input | 1 | Shift enable of the configuration chain |
| cfg_sin_i | input | 1 | Serial configuration input |
| cfg_sout_o | output | 1 | Serial configuration output (last pixel, bit 5) |
| tune_o | output | NPIX*4 | Threshold tuning value per pixel |
| rd_shift_i | input | 1 | Readout shift enable |
| rd_sin_i | input | 1 | Serial readout input into pixel 0 |
| rd_sout_o | output | 1 | Serial readout output (last pixel, bit 7) |
| hit_o | output | NPIX | Per-pixel hit flag |

## Verification
On every cycle the assertions check that configuration and data registers hold when no shift or acquisition enables them, that a saturated arrival field stays at 15, that a masked pixel never raises its flag, that a raised flag survives until the next opening, that each readout shift takes in the serial input bit, and that a shutter opening clears every flag. Only the bench scenarios can show the actual measured values: arrival and duration for short, long and repeated pulses, the ignored pulse at the opening edge, counting-mode totals up to saturation, test-pulse routing, and the bit order of the configuration and readout chains.

// File: rtl/pix_pkg.sv
package pix_pkg;

    localparam int CNT_W  = 4;
    localparam int TUNE_W = 4;
    localparam int DATA_W = 2 * CNT_W;
    localparam int CFG_W  = TUNE_W + 2;

    typedef enum logic {
        MODE_TIME  = 1'b0,
        MODE_COUNT = 1'b1
    } acq_mode_e;

    typedef struct packed {
        logic              mask;
        logic              tpen;
        logic [TUNE_W-1:0] tune;
    } pix_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] toa;
        logic [CNT_W-1:0] tot;
    } pix_data_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

    function automatic logic [DATA_W-1:0] sat_inc_word(input logic [DATA_W-1:0] v);
        return (v == {DATA_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pix_cfg_stage.sv
module pix_cfg_stage
    import pix_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     shift_i,
    input  logic     sin_i,
    output pix_cfg_t cfg_o,
    output logic     sout_o
);

    pix_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (shift_i) begin
            cfg_q <= {cfg_q[CFG_W-2:0], sin_i};
        end
    end

    assign cfg_o  = cfg_q;
    assign sout_o = cfg_q[CFG_W-1];

    // R2: configuration word holds when the chain is not shifting
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(cfg_q));

    // R2: a shift takes in the serial bit at the bottom
    p_cfg_take_r2: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (cfg_q[0] == $past(sin_i)));

endmodule

// File: rtl/pix_meas.sv
module pix_meas
    import pix_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  acq_mode_e mode_i,
    input  logic      open_i,
    input  logic      armed_i,
    input  logic      shift_i,
    input  logic      sin_i,
    input  logic      level_i,
    input  logic      mask_i,
    output pix_data_t data_o,
    output logic      hit_o,
    output logic      sout_o
);

    pix_data_t data_q;
    logic      hit_q;
    logic      run_q;
    logic      lvl_prev_q;
    logic      rise;

    assign rise = level_i & ~lvl_prev_q & armed_i & ~mask_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev_q <= 1'b0;
        end else begin
            lvl_prev_q <= level_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            hit_q  <= 1'b0;
            run_q  <= 1'b0;
        end else if (open_i) begin
            data_q <= '0;
            hit_q  <= 1'b0;
            run_q  <= 1'b0;
        end else if (armed_i) begin
            if (mode_i == MODE_COUNT) begin
                if (rise) begin
                    data_q <= sat_inc_word(data_q);
                    hit_q  <= 1'b1;
                end
            end else if (hit_q) begin
                data_q.toa <= sat_inc(data_q.toa);
                if (run_q) begin
                    if (level_i) begin
                        data_q.tot <= sat_inc(data_q.tot);
                    end else begin
                        run_q <= 1'b0;
                    end
                end
            end else if (rise) begin
                hit_q <= 1'b1;
                run_q <= 1'b1;
            end
        end else if (shift_i) begin
            data_q <= {data_q[DATA_W-2:0], sin_i};
        end
    end

    assign data_o = data_q;
    assign hit_o  = hit_q;
    assign sout_o = data_q[DATA_W-1];

    // R4: a saturated arrival field stays saturated while acquiring in timing mode
    p_toa_sat_r4: assert property (@(posedge clk) disable iff (rst)
        (armed_i && mode_i == MODE_TIME && data_q.toa == {CNT_W{1'b1}})
        |=> (data_q.toa == {CNT_W{1'b1}}));

    // R8: a masked pixel never raises its flag
    p_mask_no_hit_r8: assert property (@(posedge clk) disable iff (rst)
        (mask_i && !hit_q) |=> !hit_q);

    // R11: a raised flag survives until the next opening
    p_hit_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (hit_q && !open_i) |=> hit_q);

    // R10: data holds when neither acquiring nor shifting
    p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!armed_i && !open_i && !shift_i) |=> $stable(data_q));

    // R10: a readout shift takes in the serial bit at the bottom
    p_rd_take_r10: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !armed_i && !open_i) |=> (data_q[0] == $past(sin_i)));

endmodule

// File: rtl/pix_cell.sv
module pix_cell
    import pix_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acq_mode_e         mode_i,
    input  logic              open_i,
    input  logic              armed_i,
    input  logic              rd_shift_i,
    input  logic              rd_sin_i,
    output logic              rd_sout_o,
    input  logic              cfg_shift_i,
    input  logic              cfg_sin_i,
    output logic              cfg_sout_o,
    input  logic              disc_i,
    input  logic              tp_pulse_i,
    output logic              hit_o,
    output logic [TUNE_W-1:0] tune_o
);

    pix_cfg_t  cfg;
    pix_data_t data;
    logic      level;

    pix_cfg_stage u_cfg (
        .clk     (clk),
        .rst     (rst),
        .shift_i (cfg_shift_i),
        .sin_i   (cfg_sin_i),
        .cfg_o   (cfg),
        .sout_o  (cfg_sout_o)
    );

    assign level = cfg.tpen ? tp_pulse_i : disc_i;

    pix_meas u_meas (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode_i),
        .open_i  (open_i),
        .armed_i (armed_i),
        .shift_i (rd_shift_i),
        .sin_i   (rd_sin_i),
        .level_i (level),
        .mask_i  (cfg.mask),
        .data_o  (data),
        .hit_o   (hit_o),
        .sout_o  (rd_sout_o)
    );

    assign tune_o = cfg.tune;

endmodule

// File: rtl/pix_column.sv
module pix_column
    import pix_pkg::*;
#(
    parameter int NPIX = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shutter_i,
    input  logic                   mode_i,
    input  logic                   tp_pulse_i,
    input  logic [NPIX-1:0]        disc_i,
    input  logic                   cfg_shift_i,
    input  logic                   cfg_sin_i,
    output logic                   cfg_sout_o,
    output logic [NPIX*TUNE_W-1:0] tune_o,
    input  logic                   rd_shift_i,
    input  logic                   rd_sin_i,
    output logic                   rd_sout_o,
    output logic [NPIX-1:0]        hit_o
);

    logic      shut_q;
    logic      open_w;
    logic      armed_w;
    logic      rd_ok;
    acq_mode_e mode;
    logic [NPIX:0] cfg_link;
    logic [NPIX:0] rd_link;

    always_ff @(posedge clk) begin
        if (rst) begin
            shut_q <= 1'b0;
        end else begin
            shut_q <= shutter_i;
        end
    end

    assign open_w  = shutter_i & ~shut_q;
    assign armed_w = shutter_i & shut_q;
    assign rd_ok   = rd_shift_i & ~shutter_i;
    assign mode    = acq_mode_e'(mode_i);

    assign cfg_link[0] = cfg_sin_i;
    assign rd_link[0]  = rd_sin_i;

    for (genvar k = 0; k < NPIX; k++) begin : g_pix
        pix_cell u_cell (
            .clk         (clk),
            .rst         (rst),
            .mode_i      (mode),
            .open_i      (open_w),
            .armed_i     (armed_w),
            .rd_shift_i  (rd_ok),
            .rd_sin_i    (rd_link[k]),
            .rd_sout_o   (rd_link[k+1]),
            .cfg_shift_i (cfg_shift_i),
            .cfg_sin_i   (cfg_link[k]),
            .cfg_sout_o  (cfg_link[k+1]),
            .disc_i      (disc_i[k]),
            .tp_pulse_i  (tp_pulse_i),
            .hit_o       (hit_o[k]),
            .tune_o      (tune_o[k*TUNE_W +: TUNE_W])
        );
    end

    assign cfg_sout_o = cfg_link[NPIX];
    assign rd_sout_o  = rd_link[NPIX];

    // R3: an opening edge leaves every flag cleared
    p_open_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (shutter_i && !shut_q) |=> (hit_o == '0));

    // R1: reset clears the flags and serial outputs
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (hit_o == '0 && rd_sout_o == 1'b0 && cfg_sout_o == 1'b0));

endmodule

// File: tb/pix_column_tb_top.sv
module pix_column_tb_top;

    localparam int NPIX = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                shutter_i = 1'b0;
    logic                mode_i = 1'b0;
    logic                tp_pulse_i = 1'b0;
    logic [NPIX-1:0]     disc_i = '0;
    logic                cfg_shift_i = 1'b0;
    logic                cfg_sin_i = 1'b0;
    logic                cfg_sout_o;
    logic [NPIX*4-1:0]   tune_o;
    logic                rd_shift_i = 1'b0;
    logic                rd_sin_i = 1'b0;
    logic                rd_sout_o;
    logic [NPIX-1:0]     hit_o;

    always #4 clk = ~clk;

    pix_column #(.NPIX(NPIX)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .shutter_i   (shutter_i),
        .mode_i      (mode_i),
        .tp_pulse_i  (tp_pulse_i),
        .disc_i      (disc_i),
        .cfg_shift_i (cfg_shift_i),
        .cfg_sin_i   (cfg_sin_i),
        .cfg_sout_o  (cfg_sout_o),
        .tune_o      (tune_o),
        .rd_shift_i  (rd_shift_i),
        .rd_sin_i    (rd_sin_i),
        .rd_sout_o   (rd_sout_o),
        .hit_o       (hit_o)
    );

    typedef struct {
        string      tag;
        logic [7:0] val;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] got_q[$];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    // bench-side copy of the configuration it sends
    bit       c_mask [NPIX];
    bit       c_tp   [NPIX];
    bit [3:0] c_tune [NPIX];

    // stimulus pattern per source: index NPIX is the test pulse
    int st [NPIX+1];
    int ln [NPIX+1];
    int per[NPIX+1];
    int st2[NPIX+1];
    int ln2[NPIX+1];

    bit [NPIX-1:0] exp_hit;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic bit hi(input int s, input int c);
        bit a;
        if (per[s] == 0) a = (c >= st[s]) && (c < st[s] + ln[s]);
        else             a = (c >= st[s]) && (((c - st[s]) % per[s]) < ln[s]);
        return a || ((c >= st2[s]) && (c < st2[s] + ln2[s]));
    endfunction

    function automatic logic [7:0] model(input int s, input int len, input bit cnt, output bit h);
        int first;
        int k;
        int toa;
        int n;
        h = 1'b0;
        if (cnt) begin
            n = 0;
            for (int c = 1; c < len; c++) if (hi(s, c) && !hi(s, c-1)) n++;
            h = (n > 0);
            return (n > 255) ? 8'd255 : 8'(n);
        end
        first = -1;
        for (int c = 1; c < len; c++) begin
            if (first < 0 && hi(s, c) && !hi(s, c-1)) first = c;
        end
        if (first < 0) return 8'd0;
        h = 1'b1;
        toa = len - 1 - first;
        if (toa > 15) toa = 15;
        k = 0;
        for (int j = first + 1; j < len && hi(s, j); j++) k++;
        if (k > 15) k = 15;
        return {4'(toa), 4'(k)};
    endfunction

    task automatic clear_pat();
        for (int s = 0; s <= NPIX; s++) begin
            st[s] = 0; ln[s] = 0; per[s] = 0; st2[s] = 0; ln2[s] = 0;
        end
    endtask

    task automatic load_cfg();
        for (int p = NPIX-1; p >= 0; p--) begin
            logic [5:0] w;
            w = {c_mask[p], c_tp[p], c_tune[p]};
            for (int b = 5; b >= 0; b--) begin
                cfg_sin_i   = w[b];
                cfg_shift_i = 1'b1;
                @(negedge clk);
            end
        end
        cfg_shift_i = 1'b0;
        cfg_sin_i   = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_cfg(input string tag);
        logic [NPIX*4-1:0] t;
        for (int p = 0; p < NPIX; p++) t[p*4 +: 4] = c_tune[p];
        chk({tag, " tune_o"}, tune_o, t);
        chk({tag, " cfg_sout_o"}, cfg_sout_o, c_mask[NPIX-1]);
    endtask

    // driver: runs one shutter window and pushes expected words
    task automatic acq(input int len, input bit cnt, input bit shift_inside, input string tag);
        mode_i = cnt;
        for (int p = NPIX-1; p >= 0; p--) begin
            int         src;
            bit         h;
            item_t      it;
            logic [7:0] v;
            src = c_tp[p] ? NPIX : p;
            v = model(src, len, cnt, h);
            if (c_mask[p]) begin v = 8'd0; h = 1'b0; end
            exp_hit[p] = h;
            it.tag = $sformatf("%s pixel%0d", tag, p);
            it.val = v;
            exp_q.push_back(it);
        end
        for (int c = 0; c < len; c++) begin
            shutter_i = 1'b1;
            for (int p = 0; p < NPIX; p++) disc_i[p] = hi(p, c);
            tp_pulse_i = hi(NPIX, c);
            if (shift_inside) begin rd_shift_i = 1'b1; rd_sin_i = 1'b1; end
            @(negedge clk);
        end
        shutter_i  = 1'b0;
        disc_i     = '0;
        tp_pulse_i = 1'b0;
        rd_shift_i = 1'b0;
        rd_sin_i   = 1'b0;
        @(negedge clk);
        chk({tag, " hit_o"}, hit_o, exp_hit);
    endtask

    task automatic readout(input string tag);
        for (int i = 0; i < NPIX; i++) begin
            logic [7:0] w;
            w = '0;
            for (int b = 0; b < 8; b++) begin
                w = {w[6:0], rd_sout_o};
                rd_shift_i = 1'b1;
                rd_sin_i   = 1'b0;
                @(negedge clk);
            end
            got_q.push_back(w);
        end
        rd_shift_i = 1'b0;
        @(negedge clk);
        chk({tag, " R10 chain refilled"}, rd_sout_o, 1'b0);
        chk({tag, " R11 hit held after readout"}, hit_o, exp_hit);
        while (got_q.size() > 0) @(negedge clk);
    endtask

    // monitor: pops each produced word against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [7:0] g;
                item_t      e;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected word", g, 8'hxx);
                end else begin
                    e = exp_q.pop_front();
                    chk(e.tag, g, e.val);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 hit_o", hit_o, '0);
        chk("R1 tune_o", tune_o, '0);
        chk("R1 rd_sout_o", rd_sout_o, 1'b0);
        chk("R1 cfg_sout_o", cfg_sout_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        // configuration: pixel2 masked, pixel3 on test pulse
        c_mask = '{0, 0, 1, 0};
        c_tp   = '{0, 0, 0, 1};
        c_tune = '{4'h5, 4'hA, 4'h3, 4'hF};
        load_cfg();
        check_cfg("R2 load1");
        repeat (5) @(negedge clk);
        check_cfg("R2 hold");

        // acq1: plain, short, repeated, masked and test-pulse pixels
        clear_pat();
        st[0] = 3; ln[0] = 5;
        st[1] = 6; ln[1] = 1; st2[1] = 8; ln2[1] = 2;
        st[2] = 2; ln[2] = 3;
        st[3] = 2; ln[3] = 6;
        st[NPIX] = 4; ln[NPIX] = 2;
        acq(12, 1'b0, 1'b0, "R4 R5 R6 R8 R9 acq1");
        check_cfg("R2 after acq1");
        readout("R10 acq1");

        // acq2: saturation, pulse at opening edge, shift request ignored
        clear_pat();
        st[0] = 1; ln[0] = 25;
        st[1] = 0; ln[1] = 3;
        st[3] = 4; ln[3] = 3;
        st[NPIX] = 20; ln[NPIX] = 30;
        acq(30, 1'b0, 1'b1, "R3 R4 R5 R10 acq2");
        readout("R10 acq2");

        // acq3: counting mode with saturation
        clear_pat();
        st[0] = 1; ln[0] = 1; per[0] = 3;
        st[1] = 2; ln[1] = 1; per[1] = 2;
        st[2] = 1; ln[2] = 1; per[2] = 2;
        st[NPIX] = 3; ln[NPIX] = 2; per[NPIX] = 4;
        acq(600, 1'b1, 1'b0, "R7 R8 R9 acq3");
        readout("R10 acq3");

        // reconfigure: unmask pixel2, pixel3 back on its own input
        c_mask = '{0, 0, 0, 0};
        c_tp   = '{0, 0, 0, 0};
        c_tune = '{4'h1, 4'h2, 4'hC, 4'h9};
        load_cfg();
        check_cfg("R2 load2");

        clear_pat();
        st[2] = 2; ln[2] = 2;
        st[3] = 5; ln[3] = 1;
        st[NPIX] = 1; ln[NPIX] = 5;
        acq(10, 1'b0, 1'b0, "R4 R5 R8 R9 acq4");
        readout("R10 acq4");

        // reset again clears everything
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 second reset hit_o", hit_o, '0);
        chk("R1 second reset tune_o", tune_o, '0);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule